// File: doc/BRIEF.md
# Prescaled Saturating Charge Accumulator

This block turns a stream of signed charge pulses from an integrator front end into a 16-bit accumulated charge count. Each pulse is a single-cycle strobe on either the charge-in line or the charge-out line. A signed prescaler divides the stream by a power of two. The count moves by one each time the prescaler completes a full step in either direction.

The count is pinned at both ends of its range and never wraps. Any step that would carry it past either end leaves a sticky saturation event for the status logic; the consumer acknowledges it with a clear strobe. A charger can report a full battery through a level input. While that input is high and its mode is enabled, the count is held at full scale. The host can shut off counting, and can load the count directly.

Top module: `chg_accum_top`

## Requirements
- R1: While reset is high and in the first cycle after it falls, the count is 0x7FFF, the saturation event is 0 and the prescaler residue is zero.
- R2: With exponent k on `scale_exp`, starting from a cleared residue, exactly 2^k net charge-in pulses raise the count by one, and fewer pulses leave it unchanged. k = 0 therefore steps the count on every pulse.
- R3: The count changes by exactly one per prescaler completion. The change appears at the same clock edge that samples the completing pulse.
- R4: The count never wraps. A charge-in step at 0xFFFF leaves 0xFFFF, and a charge-out step at 0x0000 leaves 0x0000.
- R5: A step blocked by R4 sets `sat_evt` at that edge. The event stays set until an `evt_clr` strobe in a cycle with no new blocked step. A blocked step in the same cycle as `evt_clr` keeps the event set.
- R6: While `cc_mode_en` and `cc_in` are both high, the count is forced to 0xFFFF, pulses are dropped and the residue is cleared. Counting resumes in the first cycle after `cc_in` falls. `cc_in` has no effect while `cc_mode_en` is low.
- R7: While `shutdown` is high, pulses are dropped, the residue is cleared and the count keeps its value.
- R8: `host_wr` loads `host_data` into the count at the next edge. It takes priority over charge-complete forcing and over steps, including while `shutdown` is high.
- R9: A charge-in and a charge-out pulse in the same cycle cancel, and the residue does not change.
- R10: In a cycle where `scale_exp` differs from its value in the previous cycle, the residue is cleared and that cycle's pulses are dropped.
- R11: The residue is signed. From zero, 2^k net charge-out pulses lower the count by one, and the residue never leaves the range ±(2^k − 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chg_up | input | 1 | Single-cycle charge-in pulse |
| chg_dn | input | 1 | Single-cycle charge-out pulse |
| scale_exp | input | 3 | Prescaler exponent k, division factor 2^k |
| cc_mode_en | input | 1 | Enables the charge-complete input |
| cc_in | input | 1 | Charge-complete level from the charger |
| shutdown | input | 1 | Stops counting and clears the residue |
| host_wr | input | 1 | Host load strobe for the count |
| host_data | input | 16 | Value loaded by `host_wr` |
| evt_clr | input | 1 | Acknowledge strobe for the saturation event |
| acc_value | output | 16 | Accumulated charge count |
| sat_evt | output | 1 | Sticky saturation event |

## Verification
Two pairs of functions can land in the same cycle, and both pairs are exercised. The first pair is a blocked step at a range end and the acknowledge of the saturation event. The bench loads 0xFFFF with the exponent at zero, then pulses `chg_up` together with `evt_clr`, and expects the event to stay set. The second pair is a prescaler completion and a host load or charge-complete force. The random phase often places host loads at the range ends and toggles charge-complete at random. A reference model applies the priority order write, then force, then step, and is compared with both outputs in every cycle.

// File: rtl/chg_pkg.sv
package chg_pkg;

    localparam int unsigned CHG_ACC_W = 16;
    localparam int unsigned CHG_EXP_W = 3;

    // one-cycle step request leaving the prescaler
    typedef struct packed {
        logic inc;
        logic dec;
    } step_t;

    // which source updates the count in a cycle
    typedef enum logic [2:0] {
        SRC_KEEP = 3'd0,
        SRC_HOST = 3'd1,
        SRC_FULL = 3'd2,
        SRC_INC  = 3'd3,
        SRC_DEC  = 3'd4
    } acc_src_e;

    // priority: host load, then charge-complete force, then a step
    function automatic acc_src_e pick_src(input logic wr, input logic full, input step_t st);
        acc_src_e s;
        if (wr)          s = SRC_HOST;
        else if (full)   s = SRC_FULL;
        else if (st.inc) s = SRC_INC;
        else if (st.dec) s = SRC_DEC;
        else             s = SRC_KEEP;
        return s;
    endfunction

endpackage

// File: rtl/chg_prescaler.sv
module chg_prescaler
    import chg_pkg::*;
#(
    parameter int unsigned EXP_W = CHG_EXP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pulse_up,
    input  logic             pulse_dn,
    input  logic [EXP_W-1:0] scale_exp,
    input  logic             flush,
    output step_t            step
);
    localparam int unsigned RES_W = 1 << EXP_W;
    localparam logic [RES_W-1:0] ONE = RES_W'(1);

    logic [EXP_W-1:0]        exp_q;
    logic signed [RES_W-1:0] residue, res_d;
    logic [RES_W-1:0]        lim_now, lim_old;
    logic signed [RES_W-1:0] lim_s, lim_old_s;
    logic                    exp_changed;

    assign exp_changed = (scale_exp != exp_q);
    assign lim_now     = (ONE << scale_exp) - ONE;
    assign lim_old     = (ONE << exp_q) - ONE;
    assign lim_s       = $signed(lim_now);
    assign lim_old_s   = $signed(lim_old);

    always_comb begin
        res_d = residue;
        step  = '0;
        if (flush || exp_changed) begin
            res_d = '0;
        end else if (pulse_up && !pulse_dn) begin
            if (residue == lim_s) begin
                res_d    = '0;
                step.inc = 1'b1;
            end else begin
                res_d = residue + $signed(ONE);
            end
        end else if (pulse_dn && !pulse_up) begin
            if (residue == -lim_s) begin
                res_d    = '0;
                step.dec = 1'b1;
            end else begin
                res_d = residue - $signed(ONE);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            residue <= '0;
            exp_q   <= scale_exp;
        end else begin
            residue <= res_d;
            exp_q   <= scale_exp;
        end
    end

    AST_RES_RANGE: assert property (@(posedge clk) disable iff (rst)
        (residue <= lim_old_s) && (residue >= -lim_old_s)); // R11

    AST_CANCEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pulse_up && pulse_dn && !flush && !exp_changed) |=> $stable(residue)); // R9

    AST_EXP_CLEAR: assert property (@(posedge clk) disable iff (rst)
        exp_changed |=> (residue == '0)); // R10

    AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (rst)
        flush |=> (residue == '0)); // R7

    AST_STEP_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(step.inc && step.dec)); // R3

endmodule

// File: rtl/chg_acc_reg.sv
module chg_acc_reg
    import chg_pkg::*;
#(
    parameter int unsigned ACC_W = CHG_ACC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [ACC_W-1:0] wr_data,
    input  logic             force_full,
    input  step_t            step,
    output logic [ACC_W-1:0] value,
    output logic             sat_hit
);
    localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};
    localparam logic [ACC_W-1:0] ACC_MIN = '0;
    localparam logic [ACC_W-1:0] ACC_MID = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] ACC_ONE = ACC_W'(1);

    acc_src_e         src;
    logic [ACC_W-1:0] value_d;

    assign src = pick_src(wr_en, force_full, step);

    always_comb begin
        value_d = value;
        sat_hit = 1'b0;
        unique case (src)
            SRC_HOST: value_d = wr_data;
            SRC_FULL: value_d = ACC_MAX;
            SRC_INC: begin
                if (value == ACC_MAX) sat_hit = 1'b1;
                else                  value_d = value + ACC_ONE;
            end
            SRC_DEC: begin
                if (value == ACC_MIN) sat_hit = 1'b1;
                else                  value_d = value - ACC_ONE;
            end
            default: value_d = value;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) value <= ACC_MID;
        else     value <= value_d;
    end

    AST_MID_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (value == ACC_MID)); // R1

    AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (rst)
        (value == ACC_MAX && !wr_en) |=> (value != ACC_MIN)); // R4

    AST_NO_WRAP_BOT: assert property (@(posedge clk) disable iff (rst)
        (value == ACC_MIN && !wr_en && !force_full) |=> (value != ACC_MAX)); // R4

    AST_CC_FULL: assert property (@(posedge clk) disable iff (rst)
        (force_full && !wr_en) |=> (value == ACC_MAX)); // R6

    AST_HOST_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (value == $past(wr_data))); // R8

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !force_full && (step.inc || step.dec) && !sat_hit)
        |=> (value != $past(value))); // R3

endmodule

// File: rtl/chg_sat_flag.sv
module chg_sat_flag (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic clr,
    output logic evt
);
    always_ff @(posedge clk) begin
        if (rst)      evt <= 1'b0;
        else if (hit) evt <= 1'b1;
        else if (clr) evt <= 1'b0;
    end

    AST_EVT_SET: assert property (@(posedge clk) disable iff (rst)
        hit |=> evt); // R5

    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (evt && !clr) |=> evt); // R5

    AST_EVT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr && !hit) |=> !evt); // R5

endmodule

// File: rtl/chg_accum_top.sv
module chg_accum_top
    import chg_pkg::*;
#(
    parameter int unsigned ACC_W = CHG_ACC_W,
    parameter int unsigned EXP_W = CHG_EXP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chg_up,
    input  logic             chg_dn,
    input  logic [EXP_W-1:0] scale_exp,
    input  logic             cc_mode_en,
    input  logic             cc_in,
    input  logic             shutdown,
    input  logic             host_wr,
    input  logic [ACC_W-1:0] host_data,
    input  logic             evt_clr,
    output logic [ACC_W-1:0] acc_value,
    output logic             sat_evt
);
    logic  force_full;
    logic  flush;
    logic  sat_hit;
    step_t step;

    assign force_full = cc_mode_en && cc_in;
    assign flush      = shutdown || force_full;

    chg_prescaler #(.EXP_W(EXP_W)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .pulse_up  (chg_up),
        .pulse_dn  (chg_dn),
        .scale_exp (scale_exp),
        .flush     (flush),
        .step      (step)
    );

    chg_acc_reg #(.ACC_W(ACC_W)) u_acc (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (host_wr),
        .wr_data    (host_data),
        .force_full (force_full),
        .step       (step),
        .value      (acc_value),
        .sat_hit    (sat_hit)
    );

    chg_sat_flag u_flag (
        .clk (clk),
        .rst (rst),
        .hit (sat_hit),
        .clr (evt_clr),
        .evt (sat_evt)
    );

    AST_SHUTDOWN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (shutdown && !host_wr && !force_full) |=> $stable(acc_value)); // R7

    AST_SHUTDOWN_NO_EVT: assert property (@(posedge clk) disable iff (rst)
        (shutdown && !sat_evt) |=> !sat_evt); // R7

endmodule

// File: tb/chg_accum_top_tb.sv
module chg_accum_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chg_up = 1'b0, chg_dn = 1'b0;
    logic [2:0]  scale_exp = 3'd7;
    logic        cc_mode_en = 1'b0, cc_in = 1'b0, shutdown = 1'b0;
    logic        host_wr = 1'b0, evt_clr = 1'b0;
    logic [15:0] host_data = '0;
    logic [15:0] acc_value;
    logic        sat_evt;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    int m_acc, m_res, m_expp;
    bit m_evt;

    always #2 clk = ~clk;

    chg_accum_top u_dut (
        .clk(clk), .rst(rst), .chg_up(chg_up), .chg_dn(chg_dn),
        .scale_exp(scale_exp), .cc_mode_en(cc_mode_en), .cc_in(cc_in),
        .shutdown(shutdown), .host_wr(host_wr), .host_data(host_data),
        .evt_clr(evt_clr), .acc_value(acc_value), .sat_evt(sat_evt)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void model_edge();
        int  lim;
        bit  inc, dec, hit, frc;
        lim = (1 << scale_exp) - 1;
        frc = cc_mode_en && cc_in;
        inc = 0; dec = 0; hit = 0;
        if (rst) begin
            m_acc = 16'h7FFF; m_res = 0; m_evt = 0; m_expp = scale_exp;
            return;
        end
        if (shutdown || frc || (int'(scale_exp) != m_expp)) m_res = 0;
        else if (chg_up && !chg_dn) begin
            if (m_res == lim) begin m_res = 0; inc = 1; end else m_res++;
        end else if (chg_dn && !chg_up) begin
            if (m_res == -lim) begin m_res = 0; dec = 1; end else m_res--;
        end
        m_expp = scale_exp;
        if (host_wr) m_acc = host_data;
        else if (frc) m_acc = 16'hFFFF;
        else if (inc) begin if (m_acc == 16'hFFFF) hit = 1; else m_acc++; end
        else if (dec) begin if (m_acc == 0) hit = 1; else m_acc--; end
        m_evt = hit | (m_evt & !evt_clr);
    endfunction

    // one clock: inputs already driven at negedge; model at edge; compare at next negedge
    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check("R2 R3 R4 R6 R7 R8 R9 R10 R11 count", acc_value, m_acc);
        check("R5 event", sat_evt, m_evt);
        chg_up = 0; chg_dn = 0; host_wr = 0; evt_clr = 0;
    endtask

    task automatic pulses(input bit up, input int n);
        for (int i = 0; i < n; i++) begin
            chg_up = up; chg_dn = !up; tick();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        tick(); tick();
        rst = 0;
        tick();
        check("R1 reset count", acc_value, 16'h7FFF);
        check("R1 reset event", sat_evt, 0);

        // R2: k=2 needs four pulses
        scale_exp = 3'd2; tick();
        pulses(1, 3);
        check("R2 below 2^k", acc_value, 16'h7FFF);
        pulses(1, 1);
        check("R2 R3 step at 2^k", acc_value, 16'h8000);

        // R11: signed residue downward
        pulses(0, 3);
        check("R11 partial down", acc_value, 16'h8000);
        pulses(0, 1);
        check("R11 down step", acc_value, 16'h7FFF);

        // R9: cancel
        pulses(1, 3);
        chg_up = 1; chg_dn = 1; tick();
        check("R9 cancel", acc_value, 16'h7FFF);
        pulses(1, 1);
        check("R9 residue kept", acc_value, 16'h8000);

        // R10: exponent change drops residue and pulse
        pulses(1, 3);
        scale_exp = 3'd3; chg_up = 1; tick();
        pulses(1, 7);
        check("R10 cleared residue", acc_value, 16'h8000);
        pulses(1, 1);
        check("R10 fresh count", acc_value, 16'h8001);

        // R7 / R8 / R4 / R5
        scale_exp = 3'd0; tick();
        shutdown = 1;
        pulses(1, 3);
        check("R7 shutdown hold", acc_value, 16'h8001);
        host_wr = 1; host_data = 16'hFFFF; tick();
        check("R8 load in shutdown", acc_value, 16'hFFFF);
        shutdown = 0;
        pulses(1, 1);
        check("R4 top hold", acc_value, 16'hFFFF);
        check("R5 event set", sat_evt, 1);
        tick();
        check("R5 sticky", sat_evt, 1);
        evt_clr = 1; tick();
        check("R5 cleared", sat_evt, 0);
        evt_clr = 1; chg_up = 1; tick();
        check("R5 set beats clear", sat_evt, 1);
        evt_clr = 1; tick();
        host_wr = 1; host_data = 16'h0000; tick();
        pulses(0, 1);
        check("R4 bottom hold", acc_value, 16'h0000);
        check("R5 bottom event", sat_evt, 1);

        // R6: charge complete
        cc_in = 1;
        pulses(1, 1);
        check("R6 ignored when disabled", acc_value, 16'h0001);
        cc_mode_en = 1; tick();
        check("R6 forced full", acc_value, 16'hFFFF);
        pulses(0, 2);
        check("R6 held while high", acc_value, 16'hFFFF);
        cc_in = 0;
        pulses(0, 1);
        check("R6 resumes after low", acc_value, 16'hFFFE);

        // random phase
        for (int c = 0; c < 6000; c++) begin
            int r;
            r = int'($urandom_range(0, 3));
            chg_up = (r == 1) || (r == 3);
            chg_dn = (r == 2) || (r == 3);
            if ($urandom_range(0, 63) == 0) scale_exp = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 99) == 0) shutdown = !shutdown;
            if ($urandom_range(0, 79) == 0) cc_mode_en = !cc_mode_en;
            if ($urandom_range(0, 49) == 0) cc_in = !cc_in;
            if ($urandom_range(0, 15) == 0) evt_clr = 1;
            if ($urandom_range(0, 149) == 0) begin
                host_wr = 1;
                case ($urandom_range(0, 3))
                    0: host_data = 16'h0000;
                    1: host_data = 16'hFFFF;
                    2: host_data = 16'h0001;
                    default: host_data = 16'($urandom);
                endcase
            end
            tick();
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule